// File: doc/BRIEF.md
# Interrupt Distributor Global Control and Type Registers

This block holds the global control word of an interrupt distributor and produces its read-only capability word. Software reaches both through a simple 32-bit register port in which every request carries a flag saying whether the requester is in the secure or the non-secure world. The control word gathers the three group enables, the two affinity-routing enables, a disable-security bit and a write-pending flag. Secure and non-secure requesters see different subsets of it and may change different subsets of it.

Affinity routing is permanently on, and updates take effect at once, so the write-pending flag never reads as set. Setting disable-security is a one-way step: it removes the split between the two worlds, clears the secure group-1 enable and the non-secure affinity-routing enable, and stays set until reset. The capability word reports fixed features, the security-extension flag (the inverse of disable-security), an optional LPI-support flag taken from a parameter, and a line count computed from the number of interrupts. Reads return data one cycle after the request.

Top module: `dist_ctl_regs`

## Requirements
- R1: After reset, a secure read of the control word (offset 0x00) returns 0x0000_0030: bit 4 (secure routing enable) and bit 5 (non-secure routing enable) set, group enables and disable-security clear.
- R2: With disable-security clear, a secure write to the control word updates bit 0 (group 0 enable), bit 1 (non-secure group 1 enable) and bit 2 (secure group 1 enable) from the written data; all other bits keep their value.
- R3: With disable-security clear, a non-secure write to the control word changes only bit 1; bits 0 and 2 keep their value.
- R4: With disable-security clear, a non-secure read of the control word returns the secure view masked to bits 31, 4 and 1.
- R5: A secure write with bit 6 set while disable-security is clear sets disable-security and clears bit 2 and bit 5 in the same update; once set, bit 6 cannot be written back to 0 and clears only on reset.
- R6: With disable-security set, only bits 0 and 1 of the control word are writable by either requester, and a non-secure read returns the full control word.
- R7: Bit 4 of the control word always reads 1 and bit 31 always reads 0, whatever is written.
- R8: The capability word (offset 0x04) reads as bits 25 and 24 set, 0xF in bits [23:19], the LPI parameter in bit 17, the inverse of disable-security in bit 10, and ((interrupt count - 32) / 32) - 1 in bits [4:0]; all other bits zero.
- R9: Writes to the capability word, the implementer-ID word (offset 0x08) and the status word (offset 0x10) have no effect; the status word reads 0 and the implementer-ID word reads its parameter value.
- R10: A read request produces rd_valid high on the next cycle with its data; a write request or an idle cycle leaves rd_valid low, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = requester is in the secure world |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data |

## Verification
The assertions watch on every cycle that disable-security never falls once set, that its rising edge always coincides with cleared secure group-1 and non-secure routing enables, that a non-secure write with security enabled leaves bits 0 and 2 alone, that non-secure reads with security enabled expose nothing outside bits 31, 4 and 1, and that read responses follow read requests by exactly one cycle. Only the bench scenarios show the exact values: the reset word, the capability word before and after disable-security, the write masks under each of the four requester and security combinations, the ignored writes to read-only words, and the return of disable-security to 0 on a second reset.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;

  // control word bit positions
  localparam int CB_EN_G0   = 0;
  localparam int CB_EN_G1NS = 1;
  localparam int CB_EN_G1S  = 2;
  localparam int CB_ARE_S   = 4;
  localparam int CB_ARE_NS  = 5;
  localparam int CB_DS      = 6;
  localparam int CB_RWP     = 31;

  // register offsets
  localparam logic [11:0] OFS_CTL  = 12'h000;
  localparam logic [11:0] OFS_TYPE = 12'h004;
  localparam logic [11:0] OFS_IID  = 12'h008;
  localparam logic [11:0] OFS_STAT = 12'h010;

  // bits a non-secure requester sees while security is enabled
  localparam logic [31:0] NS_VIEW_MASK =
    (32'h1 << CB_RWP) | (32'h1 << CB_ARE_S) | (32'h1 << CB_EN_G1NS);

  typedef struct packed {
    logic ds;
    logic are_ns;
    logic en_g1s;
    logic en_g1ns;
    logic en_g0;
  } ctl_state_t;

  typedef enum logic [2:0] {
    SEL_CTL,
    SEL_TYPE,
    SEL_IID,
    SEL_STAT,
    SEL_NONE
  } reg_sel_t;

  function automatic logic [31:0] ctl_word(input ctl_state_t s);
    logic [31:0] w;
    w = '0;
    w[CB_EN_G0]   = s.en_g0;
    w[CB_EN_G1NS] = s.en_g1ns;
    w[CB_EN_G1S]  = s.en_g1s;
    w[CB_ARE_S]   = 1'b1;
    w[CB_ARE_NS]  = s.are_ns;
    w[CB_DS]      = s.ds;
    w[CB_RWP]     = 1'b0;
    return w;
  endfunction

endpackage

// File: rtl/dist_addr_dec.sv
module dist_addr_dec
  import dist_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    if (addr == ADDR_W'(OFS_CTL))       sel = SEL_CTL;
    else if (addr == ADDR_W'(OFS_TYPE)) sel = SEL_TYPE;
    else if (addr == ADDR_W'(OFS_IID))  sel = SEL_IID;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/dist_ctl_reg.sv
module dist_ctl_reg
  import dist_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       secure,
  input  logic [6:0] wdata,
  output ctl_state_t state
);
  ctl_state_t st_q, st_d;
  logic m_g0, m_g1ns, m_g1s, m_ds;
  logic unused_mid;

  assign unused_mid = ^wdata[5:3];

  // writable bits depend on requester world and disable-security
  always_comb begin
    m_g0 = 1'b0; m_g1ns = 1'b0; m_g1s = 1'b0; m_ds = 1'b0;
    if (st_q.ds) begin
      m_g0 = 1'b1; m_g1ns = 1'b1;
    end else if (secure) begin
      m_g0 = 1'b1; m_g1ns = 1'b1; m_g1s = 1'b1; m_ds = 1'b1;
    end else begin
      m_g1ns = 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (m_g0)   st_d.en_g0   = wdata[CB_EN_G0];
      if (m_g1ns) st_d.en_g1ns = wdata[CB_EN_G1NS];
      if (m_g1s)  st_d.en_g1s  = wdata[CB_EN_G1S];
      if (m_ds && wdata[CB_DS]) begin
        st_d.ds     = 1'b1;
        st_d.en_g1s = 1'b0;
        st_d.are_ns = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '{ds: 1'b0, are_ns: 1'b1, en_g1s: 1'b0, en_g1ns: 1'b0, en_g0: 1'b0};
    end else begin
      st_q <= st_d;
    end
  end

  assign state = st_q;

  AST_DS_STICKY: assert property (@(posedge clk) disable iff (rst)
    state.ds |=> state.ds); // R5
  AST_DS_SIDE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(state.ds) |-> (!state.en_g1s && !state.are_ns)); // R5
  AST_NS_WRITE_SCOPE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !secure && !state.ds) |=> ($stable(state.en_g0) && $stable(state.en_g1s))); // R3
  AST_DS_G1S_LOW: assert property (@(posedge clk) disable iff (rst)
    state.ds |-> !state.en_g1s); // R6

endmodule

// File: rtl/dist_type_calc.sv
module dist_type_calc #(
  parameter int NUM_IRQ = 96,
  parameter bit LPI_EN  = 1'b1
) (
  input  logic        ds,
  output logic [31:0] type_word
);
  localparam int LINES = ((NUM_IRQ - 32) / 32) - 1;
  localparam logic [4:0] LINES_F = LINES[4:0];

  generate
    if (NUM_IRQ < 64 || NUM_IRQ > 1024 || (NUM_IRQ % 32) != 0) begin : g_bad_count
      initial $error("dist_type_calc: interrupt count must be a multiple of 32 in 64..1024");
    end
  endgenerate

  always_comb begin
    type_word        = '0;
    type_word[25]    = 1'b1;
    type_word[24]    = 1'b1;
    type_word[23:19] = 5'h0F;
    type_word[17]    = LPI_EN;
    type_word[10]    = ~ds;
    type_word[4:0]   = LINES_F;
  end
endmodule

// File: rtl/dist_rd_port.sv
module dist_rd_port
  import dist_regs_pkg::*;
#(
  parameter logic [31:0] IMPL_ID = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic        secure,
  input  reg_sel_t    sel,
  input  ctl_state_t  state,
  input  logic [31:0] type_word,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  logic [31:0] ctl_view, mux_d;

  always_comb begin
    ctl_view = ctl_word(state);
    if (!state.ds && !secure) ctl_view = ctl_view & NS_VIEW_MASK;
  end

  always_comb begin
    unique case (sel)
      SEL_CTL:  mux_d = ctl_view;
      SEL_TYPE: mux_d = type_word;
      SEL_IID:  mux_d = IMPL_ID;
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? mux_d : '0;
    end
  end

  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R10
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R10
  AST_NS_VIEW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_CTL && !secure && !state.ds) |=> ((rd_data & ~NS_VIEW_MASK) == 32'h0)); // R4
  AST_ROUTE_RWP: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_CTL) |=> (rd_data[CB_ARE_S] && !rd_data[CB_RWP])); // R7

endmodule

// File: rtl/dist_ctl_regs.sv
module dist_ctl_regs
  import dist_regs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          NUM_IRQ = 96,
  parameter bit          LPI_EN  = 1'b1,
  parameter logic [31:0] IMPL_ID = 32'h0100_0A5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);
  reg_sel_t    sel;
  ctl_state_t  state;
  logic [31:0] type_word;
  logic        ctl_wr, rd_en;
  logic        unused_wdata;

  assign unused_wdata = ^req_wdata[31:7];
  assign ctl_wr = req_valid && req_write && (sel == SEL_CTL);
  assign rd_en  = req_valid && !req_write;

  dist_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  dist_ctl_reg u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctl_wr),
    .secure (req_secure),
    .wdata  (req_wdata[6:0]),
    .state  (state)
  );

  dist_type_calc #(.NUM_IRQ(NUM_IRQ), .LPI_EN(LPI_EN)) u_type (
    .ds        (state.ds),
    .type_word (type_word)
  );

  dist_rd_port #(.IMPL_ID(IMPL_ID)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .secure    (req_secure),
    .sel       (sel),
    .state     (state),
    .type_word (type_word),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: tb/dist_ctl_regs_bench.sv
`timescale 1ns/1ps
module dist_ctl_regs_bench;
  localparam int          NIRQ   = 96;
  localparam logic [31:0] IID    = 32'h0100_0A5C;
  localparam logic [31:0] TYPE_S = 32'h037A_0401; // security on, 1 line group set
  localparam logic [31:0] TYPE_D = 32'h037A_0001; // after disable-security

  typedef struct packed {
    logic        wr;
    logic        sec;
    logic [7:0]  addr;
    logic [31:0] data; // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h00, 32'h0000_0030, 4'd1},  // R1 reset view
    '{1'b0, 1'b1, 8'h04, TYPE_S,        4'd8},  // R8
    '{1'b0, 1'b0, 8'h00, 32'h0000_0010, 4'd4},  // R4
    '{1'b1, 1'b1, 8'h00, 32'hFFFF_FFBF, 4'd2},  // R2 all but bit 6
    '{1'b0, 1'b1, 8'h00, 32'h0000_0037, 4'd2},  // R2 R7
    '{1'b0, 1'b0, 8'h00, 32'h0000_0012, 4'd4},  // R4
    '{1'b1, 1'b0, 8'h00, 32'hFFFF_FFFC, 4'd3},  // R3 clear bit 1 only
    '{1'b0, 1'b1, 8'h00, 32'h0000_0035, 4'd3},  // R3
    '{1'b1, 1'b0, 8'h00, 32'h0000_0002, 4'd3},  // R3
    '{1'b0, 1'b1, 8'h00, 32'h0000_0037, 4'd3},  // R3
    '{1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h00, 32'h0000_0030, 4'd2},  // R2
    '{1'b1, 1'b1, 8'h04, 32'h0000_0000, 4'd9},  // R9 write capability word
    '{1'b0, 1'b1, 8'h04, TYPE_S,        4'd9},  // R9
    '{1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF, 4'd9},  // R9 write status
    '{1'b0, 1'b1, 8'h10, 32'h0000_0000, 4'd9},  // R9
    '{1'b1, 1'b1, 8'h08, 32'h0000_0000, 4'd9},  // R9 write implementer id
    '{1'b0, 1'b0, 8'h08, IID,           4'd9},  // R9
    '{1'b0, 1'b1, 8'h20, 32'h0000_0000, 4'd10}, // R10 unmapped
    '{1'b1, 1'b1, 8'h00, 32'h0000_0045, 4'd5},  // R5 set ds, g1s, g0
    '{1'b0, 1'b1, 8'h00, 32'h0000_0051, 4'd5},  // R5
    '{1'b0, 1'b0, 8'h00, 32'h0000_0051, 4'd6},  // R6 full view
    '{1'b0, 1'b1, 8'h04, TYPE_D,        4'd8},  // R8
    '{1'b1, 1'b1, 8'h00, 32'h0000_0000, 4'd5},  // R5 try clearing ds
    '{1'b0, 1'b1, 8'h00, 32'h0000_0050, 4'd5},  // R5
    '{1'b1, 1'b0, 8'h00, 32'h0000_0003, 4'd6},  // R6
    '{1'b0, 1'b0, 8'h00, 32'h0000_0053, 4'd6},  // R6
    '{1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, 4'd6},  // R6 R7
    '{1'b0, 1'b1, 8'h00, 32'h0000_0053, 4'd7},  // R7
    '{1'b1, 1'b0, 8'h00, 32'h0000_0000, 4'd6},  // R6
    '{1'b0, 1'b1, 8'h00, 32'h0000_0050, 4'd6}   // R6
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_secure = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dist_ctl_regs #(.ADDR_W(8), .NUM_IRQ(NIRQ), .LPI_EN(1'b1), .IMPL_ID(IID)) u_dist_ctl_regs (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  // one request; returns after the capturing edge has passed
  task automatic do_req(input logic wr, input logic sec, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_secure = sec; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R1 rd_valid after reset", {31'b0, rd_valid}, 32'h0);
    check("R1 rd_data after reset", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i].wr, VECS[i].sec, VECS[i].addr, VECS[i].data);
      if (VECS[i].wr) begin
        check($sformatf("R10 no response to write, vec %0d", i), {31'b0, rd_valid}, 32'h0);
      end else begin
        check($sformatf("R%0d valid, vec %0d", VECS[i].req, i), {31'b0, rd_valid}, 32'h1);
        check($sformatf("R%0d data, vec %0d", VECS[i].req, i), rd_data, VECS[i].data);
      end
    end

    // R10: idle cycle drops rd_valid
    @(negedge clk);
    check("R10 idle rd_valid", {31'b0, rd_valid}, 32'h0);

    // R5: only reset clears disable-security
    do_reset();
    do_req(1'b0, 1'b1, 8'h00, 32'h0);
    check("R5 ds cleared by reset", rd_data, 32'h0000_0030);
    do_req(1'b0, 1'b0, 8'h04, 32'h0);
    check("R8 capability word after reset", rd_data, TYPE_S);

    // R5: ds and g1s written together -> g1s ends 0
    do_req(1'b1, 1'b1, 8'h00, 32'h0000_0046);
    do_req(1'b0, 1'b1, 8'h00, 32'h0);
    check("R5 g1s cleared with ds", rd_data, 32'h0000_0052);

    // R6: non-secure write cannot clear ds
    do_req(1'b1, 1'b0, 8'h00, 32'h0000_0001);
    do_req(1'b0, 1'b0, 8'h00, 32'h0);
    check("R6 ns write after ds", rd_data, 32'h0000_0051);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule